// File: doc/BRIEF.md
# Floating-Point Special-Value Classifier and Comparator

This block takes two binary floating-point operands per cycle and works out what kind of value each one is: zero, denormal, normal, infinity, quiet NaN or signaling NaN. It also compares the two operands in one ordered comparison. The comparison gives less-than, equal, greater-than or unordered, with the infinities placed at the two ends of the real line. A signaling NaN on either operand raises an invalid-operation flag.

When that exception is masked, the result port gives the default quiet-NaN pattern for the format, the "indefinite" value, in place of a trap. The outputs are registered, so each result appears one cycle after its operands. A surrounding execution pipeline uses the block as the front end for compare instructions and for the handling of special operands.

The exponent and fraction widths are parameters. The defaults give single precision.

Top module: `fp_special_cmp`

## Requirements
- R1: Each registered class output is a one-hot 6-bit vector. Bit 0 means zero, bit 1 denormal, bit 2 normal, bit 3 infinity, bit 4 quiet NaN and bit 5 signaling NaN.
- R2: An operand whose exponent field is all ones and whose fraction is zero is classed as infinity, whatever its sign.
- R3: An operand whose exponent field is all ones and whose fraction is non-zero is a NaN, whatever its sign. It is quiet when the top fraction bit is 1 and signaling when that bit is 0.
- R4: An exponent of zero gives zero when the fraction is zero and denormal otherwise. Any other exponent below all ones gives normal.
- R5: The compare code is 00 for equal, 01 for a below b, 10 for a above b and 11 for unordered. Any NaN operand, quiet or signaling, gives 11.
- R6: Negative infinity compares below every finite value and positive infinity above every finite value. Two infinities of the same sign compare equal.
- R7: Positive zero and negative zero compare equal.
- R8: Two finite operands are ordered first by sign, then by magnitude, with the order of magnitudes reversed when both operands are negative.
- R9: The invalid flag is 1 exactly when at least one operand is a signaling NaN. Quiet NaNs alone leave it at 0.
- R10: When the flag is set and exc_mask was 1, res_nan is 1 and res_word carries the indefinite value: sign 1, exponent all ones, only the top fraction bit set (0xFFC00000 in single precision). In every other case res_nan is 0 and res_word is zero.
- R11: out_valid is in_valid delayed by one clock. Back-to-back operands each produce their own result in the following cycle.
- R12: While reset is asserted, and after it until the first valid operand, out_valid, invalid_flag and res_nan are 0.
- R13: In a cycle with no valid result, invalid_flag and res_nan are 0. The class and compare outputs keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands and mask are valid this cycle |
| exc_mask | input | 1 | 1 = invalid exception masked, so the indefinite value is delivered |
| op_a | input | 1+EXP_W+FRAC_W | First operand (sign, exponent, fraction) |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | Registered results are valid |
| class_a | output | 6 | One-hot class of op_a |
| class_b | output | 6 | One-hot class of op_b |
| cmp_res | output | 2 | Compare code (00 eq, 01 lt, 10 gt, 11 unordered) |
| invalid_flag | output | 1 | A signaling NaN was seen |
| res_nan | output | 1 | res_word carries the masked-response NaN |
| res_word | output | 1+EXP_W+FRAC_W | Indefinite value when res_nan is 1, else zero |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths every expected value is a known single-precision pattern, including 0xFFC00000 for the indefinite value.

The same widths bring the format's edges within reach:
- the largest finite magnitude against infinity;
- the smallest denormal against both zeros;
- NaNs that differ only in the quiet bit or in the sign.

These cases exercise the borders of the class decoding and the affine ordering directly.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int CLS_W = 6;

  // class bit positions (decoded by neighbours, so fixed)
  localparam int CLS_ZERO   = 0;
  localparam int CLS_DENORM = 1;
  localparam int CLS_NORMAL = 2;
  localparam int CLS_INF    = 3;
  localparam int CLS_QNAN   = 4;
  localparam int CLS_SNAN   = 5;

  typedef logic [CLS_W-1:0] cls_t;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_LT = 2'b01,
    CMP_GT = 2'b10,
    CMP_UN = 2'b11
  } cmp_e;
endpackage

// File: rtl/fpcc_rst_sync.sv
module fpcc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_ns = out_q;
endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output fpcc_pkg::cls_t    cls_o,
  output logic              sign_o,
  output logic [MAG_W-1:0]  mag_o,
  output logic              nan_o,
  output logic              zero_o,
  output logic              snan_o
);
  import fpcc_pkg::*;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_top;
  logic              exp_bot;
  logic              frac_none;

  assign sign_o    = word_i[WORD_W-1];
  assign exp_f     = word_i[WORD_W-2 -: EXP_W];
  assign frac_f    = word_i[FRAC_W-1:0];
  assign mag_o     = word_i[MAG_W-1:0];
  assign exp_top   = &exp_f;
  assign exp_bot   = ~|exp_f;
  assign frac_none = ~|frac_f;

  always_comb begin
    cls_o = '0;
    if (exp_top) begin
      if (frac_none)               cls_o[CLS_INF]  = 1'b1;
      else if (frac_f[FRAC_W-1])   cls_o[CLS_QNAN] = 1'b1;
      else                         cls_o[CLS_SNAN] = 1'b1;
    end else if (exp_bot) begin
      if (frac_none)               cls_o[CLS_ZERO]   = 1'b1;
      else                         cls_o[CLS_DENORM] = 1'b1;
    end else begin
      cls_o[CLS_NORMAL] = 1'b1;
    end
  end

  assign nan_o  = exp_top & ~frac_none;
  assign snan_o = nan_o & ~frac_f[FRAC_W-1];
  assign zero_o = exp_bot & frac_none;
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order #(
  parameter int MAG_W = 31
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             nan_a,
  input  logic             nan_b,
  input  logic             zero_a,
  input  logic             zero_b,
  output fpcc_pkg::cmp_e   code_o
);
  import fpcc_pkg::*;

  logic a_bigger;
  logic mag_same;

  assign a_bigger = mag_a > mag_b;
  assign mag_same = mag_a == mag_b;

  // magnitude order maps to value order; infinities sit above every finite
  // magnitude, so the affine ordering falls out of the same compare
  always_comb begin
    if (nan_a || nan_b)          code_o = CMP_UN;
    else if (zero_a && zero_b)   code_o = CMP_EQ;
    else if (sign_a != sign_b)   code_o = sign_a ? CMP_LT : CMP_GT;
    else if (mag_same)           code_o = CMP_EQ;
    else if (a_bigger ^ sign_a)  code_o = CMP_GT;
    else                         code_o = CMP_LT;
  end
endmodule

// File: rtl/fpcc_invalid.sv
module fpcc_invalid #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              snan_a,
  input  logic              snan_b,
  input  logic              mask_i,
  output logic              invalid_o,
  output logic              res_nan_o,
  output logic [WORD_W-1:0] res_word_o
);
  localparam logic [WORD_W-1:0] INDEF =
    {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  assign invalid_o  = snan_a | snan_b;
  assign res_nan_o  = invalid_o & mask_i;
  assign res_word_o = res_nan_o ? INDEF : '0;
endmodule

// File: rtl/fp_special_cmp.sv
module fp_special_cmp #(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              exc_mask,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              out_valid,
  output logic [5:0]        class_a,
  output logic [5:0]        class_b,
  output logic [1:0]        cmp_res,
  output logic              invalid_flag,
  output logic              res_nan,
  output logic [WORD_W-1:0] res_word
);
  import fpcc_pkg::*;

  localparam logic [WORD_W-1:0] INDEF =
    {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic rst_ns;

  fpcc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  // per-operand decode, one instance per operand
  logic [WORD_W-1:0] ops   [2];
  cls_t              cls   [2];
  logic              sgn   [2];
  logic [MAG_W-1:0]  mag   [2];
  logic              isnan [2];
  logic              iszer [2];
  logic              issn  [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    fpcc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word_i(ops[g]),
      .cls_o (cls[g]),
      .sign_o(sgn[g]),
      .mag_o (mag[g]),
      .nan_o (isnan[g]),
      .zero_o(iszer[g]),
      .snan_o(issn[g])
    );
  end

  cmp_e cmp_c;

  fpcc_order #(.MAG_W(MAG_W)) u_ord (
    .sign_a(sgn[0]),  .sign_b(sgn[1]),
    .mag_a (mag[0]),  .mag_b (mag[1]),
    .nan_a (isnan[0]), .nan_b(isnan[1]),
    .zero_a(iszer[0]), .zero_b(iszer[1]),
    .code_o(cmp_c)
  );

  logic              inv_c;
  logic              rnan_c;
  logic [WORD_W-1:0] rword_c;

  fpcc_invalid #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_inv (
    .snan_a    (issn[0]),
    .snan_b    (issn[1]),
    .mask_i    (exc_mask),
    .invalid_o (inv_c),
    .res_nan_o (rnan_c),
    .res_word_o(rword_c)
  );

  // next-state
  logic              vld_d, inv_d, rnan_d, data_en;
  logic              vld_q, inv_q, rnan_q;
  cls_t              cla_q, clb_q;
  logic [1:0]        cmp_q;
  logic [WORD_W-1:0] rword_d, rword_q;

  always_comb begin
    data_en = in_valid;
    vld_d   = in_valid;
    inv_d   = in_valid & inv_c;
    rnan_d  = in_valid & rnan_c;
    rword_d = in_valid ? rword_c : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q   <= 1'b0;
      inv_q   <= 1'b0;
      rnan_q  <= 1'b0;
      rword_q <= '0;
      cla_q   <= '0;
      clb_q   <= '0;
      cmp_q   <= '0;
    end else begin
      vld_q   <= vld_d;
      inv_q   <= inv_d;
      rnan_q  <= rnan_d;
      rword_q <= rword_d;
      if (data_en) begin
        cla_q <= cls[0];
        clb_q <= cls[1];
        cmp_q <= cmp_c;
      end
    end
  end

  assign out_valid    = vld_q;
  assign class_a      = cla_q;
  assign class_b      = clb_q;
  assign cmp_res      = cmp_q;
  assign invalid_flag = inv_q;
  assign res_nan      = rnan_q;
  assign res_word     = rword_q;

  // assertions
  p_nan_unordered_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (vld_q && (cla_q[CLS_QNAN] || cla_q[CLS_SNAN] || clb_q[CLS_QNAN] || clb_q[CLS_SNAN]))
      |-> (cmp_q == CMP_UN));

  p_invalid_snan_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    vld_q |-> (inv_q == (cla_q[CLS_SNAN] || clb_q[CLS_SNAN])));

  p_masked_indef_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    rnan_q |-> (inv_q && rword_q == INDEF));

  p_unmasked_plain_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_valid && !exc_mask) |=> (!rnan_q && rword_q == '0));

  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    in_valid |=> vld_q);

  p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_valid |=> !vld_q);

  p_flags_idle_r13: assert property (@(posedge clk) disable iff (!rst_ns)
    !vld_q |-> (!inv_q && !rnan_q));

  p_class_onehot_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    vld_q |-> ($countones(cla_q) == 1 && $countones(clb_q) == 1));
endmodule

// File: tb/fp_special_cmp_bench.sv
module fp_special_cmp_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        exc_mask;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [5:0]  class_a, class_b;
  logic [1:0]  cmp_res;
  logic        invalid_flag, res_nan;
  logic [31:0] res_word;

  int checks = 0;
  int fails  = 0;

  fp_special_cmp u_fp_special_cmp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .exc_mask(exc_mask),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .class_a(class_a), .class_b(class_b), .cmp_res(cmp_res),
    .invalid_flag(invalid_flag), .res_nan(res_nan), .res_word(res_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [5:0] C_ZERO = 6'b000001, C_DEN = 6'b000010, C_NORM = 6'b000100,
                         C_INF = 6'b001000, C_QN = 6'b010000, C_SN = 6'b100000;
  localparam logic [1:0] EQ = 2'b00, LT = 2'b01, GT = 2'b10, UN = 2'b11;

  localparam logic [31:0] PZERO = 32'h0000_0000, NZERO = 32'h8000_0000,
    ONE = 32'h3F80_0000, TWO = 32'h4000_0000, NONE = 32'hBF80_0000,
    NTWO = 32'hC000_0000, PINF = 32'h7F80_0000, NINF = 32'hFF80_0000,
    PMAX = 32'h7F7F_FFFF, NMAX = 32'hFF7F_FFFF, DEN1 = 32'h0000_0001,
    NDEN1 = 32'h8000_0001, QNAN = 32'h7FC0_0000, NQNAN = 32'hFFC0_0001,
    SNAN = 32'h7F80_0001, NSNAN = 32'hFFBF_FFFF, INDEF = 32'hFFC0_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operand pair, sample the registered result one cycle later
  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic m);
    @(negedge clk);
    op_a = a; op_b = b; exc_mask = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; exc_mask = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R12 flags in reset", {30'd0, invalid_flag, res_nan}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R12 flags after reset", {30'd0, invalid_flag, res_nan}, 32'd0);
  endtask

  task automatic cls(input logic [31:0] w, input logic [5:0] exp, input string req);
    op(w, ONE, 1'b0);
    chk(req, {26'd0, class_a}, {26'd0, exp});
    chk("R1 class_b normal", {26'd0, class_b}, {26'd0, C_NORM});
  endtask

  task automatic t_classes;
    cls(PZERO, C_ZERO, "R4 +zero");
    cls(NZERO, C_ZERO, "R4 -zero");
    cls(DEN1,  C_DEN,  "R4 denormal");
    cls(ONE,   C_NORM, "R4 normal");
    cls(PMAX,  C_NORM, "R4 max finite");
    cls(PINF,  C_INF,  "R2 +inf");
    cls(NINF,  C_INF,  "R2 -inf");
    cls(QNAN,  C_QN,   "R3 quiet nan");
    cls(NQNAN, C_QN,   "R3 neg quiet nan");
    cls(SNAN,  C_SN,   "R3 signaling nan");
    cls(NSNAN, C_SN,   "R3 neg signaling nan");
    op(ONE, SNAN, 1'b0);
    chk("R1 class_b signaling", {26'd0, class_b}, {26'd0, C_SN});
  endtask

  task automatic cmp(input logic [31:0] a, input logic [31:0] b, input logic [1:0] exp, input string req);
    op(a, b, 1'b0);
    chk(req, {30'd0, cmp_res}, {30'd0, exp});
  endtask

  task automatic t_finite;
    cmp(ONE, TWO, LT, "R8 1<2");
    cmp(TWO, ONE, GT, "R8 2>1");
    cmp(NONE, ONE, LT, "R8 -1<1");
    cmp(NTWO, NONE, LT, "R8 -2<-1");
    cmp(NONE, NTWO, GT, "R8 -1>-2");
    cmp(ONE, ONE, EQ, "R8 1==1");
    cmp(DEN1, PZERO, GT, "R8 denorm>0");
    cmp(NDEN1, PZERO, LT, "R8 -denorm<0");
    cmp(PZERO, NZERO, EQ, "R7 +0==-0");
    cmp(NZERO, PZERO, EQ, "R7 -0==+0");
  endtask

  task automatic t_affine;
    cmp(NINF, NMAX, LT, "R6 -inf<-max");
    cmp(PINF, PMAX, GT, "R6 +inf>max");
    cmp(PZERO, PINF, LT, "R6 0<+inf");
    cmp(NINF, PZERO, LT, "R6 -inf<0");
    cmp(PINF, PINF, EQ, "R6 +inf==+inf");
    cmp(NINF, PINF, LT, "R6 -inf<+inf");
  endtask

  task automatic t_unordered;
    cmp(QNAN, ONE, UN, "R5 qnan,1");
    cmp(ONE, NSNAN, UN, "R5 1,-snan");
    cmp(QNAN, QNAN, UN, "R5 qnan,qnan");
    cmp(PINF, NQNAN, UN, "R5 inf,-qnan");
  endtask

  task automatic t_invalid;
    op(QNAN, ONE, 1'b0);  chk("R9 qnan no flag", {31'd0, invalid_flag}, 32'd0);
    op(ONE, SNAN, 1'b0);  chk("R9 snan on b", {31'd0, invalid_flag}, 32'd1);
    op(NSNAN, QNAN, 1'b0); chk("R9 snan on a", {31'd0, invalid_flag}, 32'd1);
    op(ONE, TWO, 1'b0);   chk("R9 normals no flag", {31'd0, invalid_flag}, 32'd0);
  endtask

  task automatic t_masked;
    op(SNAN, ONE, 1'b1);
    chk("R10 masked res_nan", {31'd0, res_nan}, 32'd1);
    chk("R10 masked word", res_word, INDEF);
    op(SNAN, ONE, 1'b0);
    chk("R10 unmasked res_nan", {31'd0, res_nan}, 32'd0);
    chk("R10 unmasked word", res_word, 32'd0);
    chk("R10 unmasked flag", {31'd0, invalid_flag}, 32'd1);
    op(QNAN, ONE, 1'b1);
    chk("R10 qnan masked no response", {31'd0, res_nan}, 32'd0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    op_a = SNAN; op_b = ONE; exc_mask = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk("R11 first valid", {31'd0, out_valid}, 32'd1);
    chk("R11 first flag", {31'd0, invalid_flag}, 32'd1);
    op_a = TWO; op_b = ONE; exc_mask = 1'b1;
    @(negedge clk);
    chk("R11 second valid", {31'd0, out_valid}, 32'd1);
    chk("R11 second result", {29'd0, invalid_flag, cmp_res}, {29'd0, 1'b0, GT});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11 valid drops", {31'd0, out_valid}, 32'd0);
    chk("R13 idle flags", {30'd0, invalid_flag, res_nan}, 32'd0);
    chk("R13 compare held", {30'd0, cmp_res}, {30'd0, GT});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_classes();
    t_finite();
    t_affine();
    t_unordered();
    t_invalid();
    t_masked();
    t_stream();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule